// File: doc/BRIEF.md
# Three-Wire Trim Host Sequencer

This block sits on the host side of a three-wire up/down trim device and turns one command into a correctly timed pin session. A command carries a step count from 0 to 127, a direction bit and a commit bit. It is accepted through a valid/ready handshake. The block drives an active-low select line, an increment line that counts on its falling edge, and a direction level. Every minimum interval is a parameter counted in clock cycles: select-to-first-edge setup, direction setup and hold, low and high phase widths, the gap before deselect, and the two deselect hold times.

A session ends in one of two ways. To commit, the increment line is high when select rises, and select then stays high for the long store hold. To skip the commit, the increment line is low when select rises, and the short hold follows. A command with zero steps still opens and closes a session, so a commit-only command stores the device's current position. A zero-step discard command drops the increment line while the device is still deselected. Because no falling edge is seen while selected, no step and no store take place. Both lines idle high.

Top module: `trim_link_seq`

## Requirements
- R1: Out of reset and whenever idle, `sel_n` and `pulse_n` are 1, `cmd_ready` is 1 and `done` is 0.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` stays 0 until the session ends, and `cmd_valid` pulses during that time start no extra session.
- R3: `dir_up` takes `cmd_up` (1 = toward the high end) in the cycle after acceptance and stays constant while `sel_n` is 0.
- R4: For a nonzero step count, `sel_n` is 0 with `pulse_n` at 1 for exactly max(SEL_SETUP_CYC, DIR_SETUP_CYC) cycles before the first fall of `pulse_n`.
- R5: A step count N gives exactly N falling edges of `pulse_n` while `sel_n` is 0.
- R6: Between steps, every low phase of `pulse_n` lasts exactly LOW_CYC cycles and every high phase lasts exactly HIGH_CYC cycles.
- R7: With `cmd_commit` = 1, `pulse_n` is 1 when `sel_n` rises, and `sel_n` then stays 1 for STORE_HOLD_CYC cycles before `done`.
- R8: With `cmd_commit` = 0, `pulse_n` is 0 when `sel_n` rises, and `sel_n` then stays 1 for SKIP_HOLD_CYC cycles before `done`.
- R9: A zero step count runs a session with no falling edge while selected. A zero-step discard lowers `pulse_n` for SEL_SETUP_CYC cycles with `sel_n` still 1 before selecting.
- R10: After the last `pulse_n` edge (or the lead-in, for zero steps), `sel_n` stays 0 for max(DESEL_SETUP_CYC, DIR_HOLD_CYC) more cycles. This extends the final high phase of a commit, or the final low phase of a discard.
- R11: `done` is 1 for exactly one cycle, the first idle cycle after the deselect hold, and `cmd_ready` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_steps | input | STEP_W | Number of increment pulses, 0 to 127 |
| cmd_up | input | 1 | Direction: 1 moves up, 0 moves down |
| cmd_commit | input | 1 | 1 ends with a store, 0 ends without one |
| sel_n | output | 1 | Active-low device select |
| pulse_n | output | 1 | Increment line, counted on its falling edge |
| dir_up | output | 1 | Direction level driven to the device |
| done | output | 1 | One-cycle pulse when the session has ended |

## Verification
Two events can share a cycle. The end of the last low phase can coincide with the last-step decision, where a discard keeps the line low into the tail while a commit raises it. Separately, the end of the deselect hold can coincide with a new `cmd_valid`. The bench provokes the first with step counts of 1 and 127 under both endings. For the second it keeps `cmd_valid` asserted with other data through most of a session. The bench checks the exact run-length list of the increment line against one computed from the command, and it checks that no second session opens.

// File: rtl/trim_seq_pkg.sv
package trim_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TAIL,
        PH_HOLD
    } trim_phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trim_phase_timer.sv
module trim_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/trim_step_tally.sv
module trim_step_tally #(
    parameter int unsigned SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          dec,
    output logic          last,
    output logic          none
);

    logic [SW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load) begin
            left_d = load_val;
        end else if (dec && (left_q != '0)) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign last = (left_q == SW'(1));
    assign none = (left_q == '0);

endmodule

// File: rtl/trim_link_seq.sv
module trim_link_seq
    import trim_seq_pkg::*;
#(
    parameter int unsigned STEP_W          = 7,
    parameter int unsigned SEL_SETUP_CYC   = 5,
    parameter int unsigned DIR_SETUP_CYC   = 50,
    parameter int unsigned DIR_HOLD_CYC    = 5,
    parameter int unsigned LOW_CYC         = 50,
    parameter int unsigned HIGH_CYC        = 50,
    parameter int unsigned DESEL_SETUP_CYC = 50,
    parameter int unsigned STORE_HOLD_CYC  = 1_000_000,
    parameter int unsigned SKIP_HOLD_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_up,
    input  logic              cmd_commit,
    output logic              sel_n,
    output logic              pulse_n,
    output logic              dir_up,
    output logic              done
);

    // Lead-in covers both select setup and direction setup; the tail covers
    // the deselect setup and the direction hold before the next command.
    localparam int unsigned LEAD_CYC = max_u(SEL_SETUP_CYC, DIR_SETUP_CYC);
    localparam int unsigned TAIL_CYC = max_u(DESEL_SETUP_CYC, DIR_HOLD_CYC);
    localparam int unsigned LONGEST  = max_u(max_u(max_u(LEAD_CYC, TAIL_CYC),
                                                   max_u(LOW_CYC, HIGH_CYC)),
                                             max_u(max_u(STORE_HOLD_CYC, SKIP_HOLD_CYC),
                                                   SEL_SETUP_CYC));
    localparam int unsigned CW = $clog2(LONGEST + 1);

    localparam logic [CW-1:0] ARM_LD   = CW'(SEL_SETUP_CYC - 1);
    localparam logic [CW-1:0] LEAD_LD  = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] TAIL_LD  = CW'(TAIL_CYC - 1);
    localparam logic [CW-1:0] STORE_LD = CW'(STORE_HOLD_CYC - 1);
    localparam logic [CW-1:0] SKIP_LD  = CW'(SKIP_HOLD_CYC - 1);

    typedef struct packed {
        trim_phase_e phase;
        logic        sel_n;
        logic        pulse_n;
        logic        dir;
        logic        commit;
        logic        done;
    } seq_st_t;

    localparam seq_st_t ST_RESET = '{
        phase:   PH_IDLE,
        sel_n:   1'b1,
        pulse_n: 1'b1,
        dir:     1'b0,
        commit:  1'b0,
        done:    1'b0
    };

    seq_st_t st_d, st_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          tly_load;
    logic          tly_dec;
    logic          tly_last;
    logic          tly_none;

    trim_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    trim_step_tally #(
        .SW (STEP_W)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tly_load),
        .load_val (cmd_steps),
        .dec      (tly_dec),
        .last     (tly_last),
        .none     (tly_none)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tly_load  = 1'b0;
        tly_dec   = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.sel_n   = 1'b1;
                st_d.pulse_n = 1'b1;
                if (cmd_valid) begin
                    st_d.dir    = cmd_up;
                    st_d.commit = cmd_commit;
                    tly_load    = 1'b1;
                    tmr_load    = 1'b1;
                    if ((cmd_steps == '0) && !cmd_commit) begin
                        // park the line low while still deselected
                        st_d.phase   = PH_ARM;
                        st_d.pulse_n = 1'b0;
                        tmr_val      = ARM_LD;
                    end else begin
                        st_d.phase = PH_LEAD;
                        st_d.sel_n = 1'b0;
                        tmr_val    = LEAD_LD;
                    end
                end
            end

            PH_ARM: begin
                if (tmr_expired) begin
                    st_d.phase = PH_LEAD;
                    st_d.sel_n = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LEAD_LD;
                end
            end

            PH_LEAD: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (!tly_none) begin
                        st_d.phase   = PH_LOW;
                        st_d.pulse_n = 1'b0;
                        tmr_val      = LOW_LD;
                    end else begin
                        st_d.phase = PH_TAIL;
                        tmr_val    = TAIL_LD;
                    end
                end
            end

            PH_LOW: begin
                if (tmr_expired) begin
                    tly_dec  = 1'b1;
                    tmr_load = 1'b1;
                    if (tly_last && !st_q.commit) begin
                        // discard: final low phase runs on into the tail
                        st_d.phase = PH_TAIL;
                        tmr_val    = TAIL_LD;
                    end else begin
                        st_d.phase   = PH_HIGH;
                        st_d.pulse_n = 1'b1;
                        tmr_val      = HIGH_LD;
                    end
                end
            end

            PH_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (!tly_none) begin
                        st_d.phase   = PH_LOW;
                        st_d.pulse_n = 1'b0;
                        tmr_val      = LOW_LD;
                    end else begin
                        st_d.phase = PH_TAIL;
                        tmr_val    = TAIL_LD;
                    end
                end
            end

            PH_TAIL: begin
                if (tmr_expired) begin
                    st_d.phase = PH_HOLD;
                    st_d.sel_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = st_q.commit ? STORE_LD : SKIP_LD;
                end
            end

            PH_HOLD: begin
                if (tmr_expired) begin
                    st_d.phase   = PH_IDLE;
                    st_d.pulse_n = 1'b1;
                    st_d.done    = 1'b1;
                end
            end

            default: begin
                st_d = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = (st_q.phase == PH_IDLE);
    assign sel_n     = st_q.sel_n;
    assign pulse_n   = st_q.pulse_n;
    assign dir_up    = st_q.dir;
    assign done      = st_q.done;

endmodule

// File: rtl/trim_link_seq_chk.sv
module trim_link_seq_chk #(
    parameter int unsigned LOW_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic sel_n,
    input logic pulse_n,
    input logic dir_up,
    input logic done
);

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 32'd0;
        end else if (pulse_n) begin
            low_run <= 32'd0;
        end else if (low_run != 32'hFFFF_FFFF) begin
            low_run <= low_run + 32'd1;
        end
    end

    // R1
    idle_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> sel_n);

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> !cmd_ready);

    // R3
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && $past(!sel_n)) |-> $stable(dir_up));

    // R6
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_n) && !sel_n) |-> (low_run >= LOW_CYC));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && sel_n));

endmodule

bind trim_link_seq trim_link_seq_chk #(
    .LOW_CYC (LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .sel_n     (sel_n),
    .pulse_n   (pulse_n),
    .dir_up    (dir_up),
    .done      (done)
);

// File: tb/trim_link_seq_bench.sv
module trim_link_seq_bench;

    localparam int SETUP  = 2;
    localparam int DIRSU  = 3;
    localparam int DIRHLD = 2;
    localparam int LOWC   = 4;
    localparam int HIGHC  = 3;
    localparam int DESEL  = 5;
    localparam int STORE  = 20;
    localparam int SKIP   = 6;
    localparam int LEAD   = (SETUP > DIRSU) ? SETUP : DIRSU;
    localparam int TAIL   = (DESEL > DIRHLD) ? DESEL : DIRHLD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [6:0] cmd_steps = '0;
    logic       cmd_up = 1'b0;
    logic       cmd_commit = 1'b0;
    logic       sel_n, pulse_n, dir_up, done;

    always #2 clk = ~clk;

    trim_link_seq #(
        .STEP_W (7), .SEL_SETUP_CYC (SETUP), .DIR_SETUP_CYC (DIRSU),
        .DIR_HOLD_CYC (DIRHLD), .LOW_CYC (LOWC), .HIGH_CYC (HIGHC),
        .DESEL_SETUP_CYC (DESEL), .STORE_HOLD_CYC (STORE), .SKIP_HOLD_CYC (SKIP)
    ) u_trim_link_seq (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_steps (cmd_steps), .cmd_up (cmd_up), .cmd_commit (cmd_commit),
        .sel_n (sel_n), .pulse_n (pulse_n), .dir_up (dir_up), .done (done)
    );

    int tests = 0;
    int fails = 0;
    bit wd_hit = 1'b0;
    int cycles = 0;

    // monitor state
    int ph = 3;
    int nruns, cur_len, falls, pre_low, hold_cnt, dir_bad, ready_bad, stray, done_extra;
    bit cur_lvl, rise_pulse, ready_at_done, exp_dir;
    bit run_lvl [300];
    int run_len [300];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_run();
        run_lvl[nruns] = cur_lvl;
        run_len[nruns] = cur_len;
        if (nruns < 299) nruns++;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            case (ph)
                0: begin
                    if (!sel_n) begin
                        ph = 1; nruns = 0; cur_lvl = pulse_n; cur_len = 1;
                        if (dir_up != exp_dir) dir_bad++;
                        if (cmd_ready) ready_bad++;
                    end else if (!pulse_n) pre_low++;
                end
                1: begin
                    if (cmd_ready) ready_bad++;
                    if (sel_n) begin
                        push_run();
                        rise_pulse = pulse_n;
                        hold_cnt = 1;
                        ph = 2;
                    end else begin
                        if (dir_up != exp_dir) dir_bad++;
                        if (pulse_n == cur_lvl) cur_len++;
                        else begin
                            push_run();
                            if (!pulse_n) falls++;
                            cur_lvl = pulse_n;
                            cur_len = 1;
                        end
                    end
                end
                2: begin
                    if (done) begin
                        ph = 3;
                        ready_at_done = cmd_ready;
                    end else begin
                        hold_cnt++;
                        if (cmd_ready) ready_bad++;
                    end
                end
                default: begin
                    if (done) done_extra++;
                    if (!sel_n) stray++;
                end
            endcase
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_cmd(input int n, input bit up, input bit commit, input bit junk);
        int nexp, fin, bad, hexp;
        string rq;
        nruns = 0; falls = 0; pre_low = 0; hold_cnt = 0; dir_bad = 0;
        ready_bad = 0; stray = 0; done_extra = 0; ready_at_done = 0;
        rise_pulse = 0; exp_dir = up; ph = 0;
        cmd_valid = 1'b1; cmd_steps = 7'(n); cmd_up = up; cmd_commit = commit;
        tick();
        if (junk) begin
            cmd_steps = 7'(n + 5); cmd_up = ~up; cmd_commit = ~commit;
            while (ph < 2 && !wd_hit) tick();
        end
        cmd_valid = 1'b0;
        while (ph != 3 && !wd_hit) tick();
        for (int i = 0; i < 8; i++) tick();

        nexp = (n == 0) ? 1 : (commit ? 2 * n + 1 : 2 * n);
        chk(nruns == nexp, "R5 runs", nruns, nexp);
        chk(falls == n, "R5 falls", falls, n);
        if (n > 0)
            chk(run_len[0] == LEAD && run_lvl[0] == 1'b1, "R4 lead", run_len[0], LEAD);
        else
            chk(falls == 0 && pre_low == (commit ? 0 : SETUP), "R9 zero", pre_low,
                commit ? 0 : SETUP);
        bad = 0;
        for (int i = 1; i < nruns - 1; i++)
            if (run_len[i] != (run_lvl[i] ? HIGHC : LOWC)) bad++;
        chk(bad == 0, "R6 widths", bad, 0);
        fin = (n == 0) ? LEAD + TAIL : (commit ? HIGHC + TAIL : LOWC + TAIL);
        if (nruns > 0)
            chk(run_len[nruns-1] == fin && run_lvl[nruns-1] == commit, "R10 tail",
                run_len[nruns-1], fin);
        rq = commit ? "R7" : "R8";
        hexp = commit ? STORE : SKIP;
        chk(rise_pulse == commit, rq, rise_pulse, commit);
        chk(hold_cnt == hexp, rq, hold_cnt, hexp);
        chk(dir_bad == 0 && dir_up == up, "R3 dir", dir_bad, 0);
        chk(ready_bad == 0 && stray == 0, "R2 busy", ready_bad + stray, 0);
        chk(done_extra == 0 && ready_at_done, "R11 done", done_extra, 0);
        chk(sel_n && pulse_n && cmd_ready && !done, "R1 idle", {sel_n, pulse_n, cmd_ready, done}, 4'b1110);
    endtask

    initial begin
        void'($urandom(32'd4242));
        tick();
        chk(sel_n && pulse_n && !done, "R1 in reset", {sel_n, pulse_n, done}, 3'b110);
        tick();
        rst_n = 1'b1;
        tick(); tick();
        chk(sel_n && pulse_n && cmd_ready && !done, "R1 after reset",
            {sel_n, pulse_n, cmd_ready, done}, 4'b1110);

        run_cmd(1, 1'b1, 1'b1, 1'b0);
        run_cmd(1, 1'b0, 1'b0, 1'b0);
        run_cmd(0, 1'b1, 1'b1, 1'b0);
        run_cmd(0, 1'b0, 1'b0, 1'b0);
        run_cmd(127, 1'b1, 1'b1, 1'b1);
        run_cmd(127, 1'b0, 1'b0, 1'b0);
        run_cmd(3, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 24; k++)
            run_cmd($urandom_range(0, 12), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule